// File: doc/BRIEF.md
# Three-Degree Parallel Header CRC Engine

This block computes three short CRC checksums at the same time, of degree 3, 7 and 8, over a byte stream of header fields. Words arrive one per accepted cycle at a build-time width of 8, 16 or 32 bits. A valid strobe marks the words and a last strobe marks the final one. All three checksum registers advance together on every accepted word, and the combined state is always visible as one packed 32-bit word.

Header fields that rarely change can be hashed once. The host runs the engine over those fields, reads the packed word when the run completes, and stores it. For later packets it replays that word through the resume input and streams only the fields that change. The result then equals a full run over all the fields, so the stored partial value is reused until one of the rarely-changing fields changes.

A small control FSM has three states. IDLE ignores data. RUN accepts words. DONE lasts a single cycle and raises the completion strobe. Its transitions are:
- IDLE→RUN on start or resume.
- RUN→RUN on any cycle without a final word.
- RUN→DONE when a word flagged last is accepted.
- DONE→IDLE.
- Any state→RUN on start or resume.

Top module: `hcrc_engine`

## Requirements
- R1: Each lane advances one bit at a time as fb = msb ^ bit, reg = (reg << 1) ^ (fb ? P : 0). P is 3'b011 for degree 3 (x^3+x+1), 7'b1001111 for degree 7 (x^7+x^6+x^3+x^2+x+1) and 8'h07 for degree 8 (x^8+x^2+x+1). The packed word holds degree 3 in bits [2:0], degree 7 in [9:3] and degree 8 in [17:10], with bits [31:18] always zero.
- R2: Reset, and a start pulse, load every lane with all ones. The packed word is then 32'h0003FFFF, seen in the cycle after the pulse.
- R3: A resume pulse without start loads resume_state_i, using the same bit layout as the packed word. The value is seen in the cycle after the pulse.
- R4: When start and resume are high together, start wins and the lanes load all ones.
- R5: In RUN, each cycle with valid high consumes one word. Byte 0 (bits [7:0]) is consumed first, and within each byte the least significant bit comes first. A cycle with valid low leaves the state unchanged.
- R6: done_o is high for exactly the one cycle after the word flagged last is accepted. It is low while words before the last are accepted.
- R7: Outside RUN, words presented with valid high are ignored. The packed result holds until the next start or resume.
- R8: Resuming from the packed word of a run over the first part of a message, then streaming the rest, gives the same result as one run over the whole message.
- R9: The same byte sequence gives the same packed result at word widths of 8, 16 and 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Begin a run from the all-ones value |
| resume_i | input | 1 | Begin a run from resume_state_i |
| resume_state_i | input | 18 | Saved packed state to continue from |
| valid_i | input | 1 | Data word present |
| last_i | input | 1 | Current word is the final one of the run |
| data_i | input | DATA_W | Header word, byte 0 in the low bits |
| done_o | output | 1 | One-cycle run-complete strobe |
| crc_o | output | 32 | Packed state of the three lanes |

## Verification
The bound checker checks the following on every cycle:
- the packed-word upper bits stay zero;
- start and resume load their values;
- start takes precedence over resume;
- cycles with no accepted word leave the state unchanged;
- done is a single-cycle strobe that follows an accepted last word.

Only the bench scenarios can show that the checksum values themselves are correct. The bench compares them against a bit-serial model at all three word widths and over several lengths and byte patterns, and it checks that a resumed run reproduces a full one.

// File: rtl/hcrc_pkg.sv
package hcrc_pkg;

    localparam int NUM_LANES = 3;
    localparam int PACK_W    = 18;
    localparam int RES_W     = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } hcrc_state_e;

    function automatic int lane_deg(input int idx);
        case (idx)
            0:       return 3;
            1:       return 7;
            default: return 8;
        endcase
    endfunction

    function automatic int lane_off(input int idx);
        case (idx)
            0:       return 0;
            1:       return 3;
            default: return 10;
        endcase
    endfunction

    function automatic logic [7:0] lane_poly(input int idx);
        case (idx)
            0:       return 8'h03;
            1:       return 8'h4F;
            default: return 8'h07;
        endcase
    endfunction

endpackage

// File: rtl/hcrc_lane.sv
module hcrc_lane #(
    parameter int          DEG    = 3,
    parameter logic [7:0]  POLY   = 8'h03,
    parameter int          DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DEG-1:0]    load_val_i,
    input  logic              step_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DEG-1:0]    crc_o
);

    localparam logic [DEG-1:0] TAPS = POLY[DEG-1:0];

    logic [DEG-1:0] crc_q;
    logic [DEG-1:0] crc_next;

    // Bit index ascending covers byte 0 first, LSB first inside each byte.
    function automatic logic [DEG-1:0] advance(input logic [DEG-1:0] cur,
                                               input logic [DATA_W-1:0] d);
        logic [DEG-1:0] r;
        logic           fb;
        r = cur;
        for (int i = 0; i < DATA_W; i++) begin
            fb = r[DEG-1] ^ d[i];
            r  = {r[DEG-2:0], 1'b0} ^ (fb ? TAPS : '0);
        end
        return r;
    endfunction

    always_comb crc_next = advance(crc_q, data_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            crc_q <= '1;
        else if (load_i)
            crc_q <= load_val_i;
        else if (step_i)
            crc_q <= crc_next;
    end

    assign crc_o = crc_q;

endmodule

// File: rtl/hcrc_ctrl.sv
module hcrc_ctrl
    import hcrc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic resume_i,
    input  logic valid_i,
    input  logic last_i,
    output logic load_o,
    output logic step_o,
    output logic running_o,
    output logic done_o
);

    hcrc_state_e state_q;
    hcrc_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (start_i || resume_i) begin
            state_d = ST_RUN;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_RUN:  state_d = (valid_i && last_i) ? ST_DONE : ST_RUN;
                ST_DONE: state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        load_o    = start_i || resume_i;
        step_o    = 1'b0;
        running_o = 1'b0;
        done_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN: begin
                running_o = 1'b1;
                step_o    = valid_i && !load_o;
            end
            ST_DONE: done_o = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/hcrc_engine.sv
module hcrc_engine
    import hcrc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              resume_i,
    input  logic [PACK_W-1:0] resume_state_i,
    input  logic              valid_i,
    input  logic              last_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              done_o,
    output logic [RES_W-1:0]  crc_o
);

    localparam logic [PACK_W-1:0] INIT_STATE = '1;

    logic              load;
    logic              step;
    logic              running;
    logic [PACK_W-1:0] load_val;
    logic [PACK_W-1:0] packed_state;

    hcrc_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .resume_i  (resume_i),
        .valid_i   (valid_i),
        .last_i    (last_i),
        .load_o    (load),
        .step_o    (step),
        .running_o (running),
        .done_o    (done_o)
    );

    // Start has precedence over resume.
    assign load_val = start_i ? INIT_STATE : resume_state_i;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam int D   = lane_deg(g);
        localparam int OFF = lane_off(g);
        hcrc_lane #(
            .DEG    (D),
            .POLY   (lane_poly(g)),
            .DATA_W (DATA_W)
        ) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (load),
            .load_val_i (load_val[OFF +: D]),
            .step_i     (step),
            .data_i     (data_i),
            .crc_o      (packed_state[OFF +: D])
        );
    end

    assign crc_o = {{(RES_W-PACK_W){1'b0}}, packed_state};

endmodule

// File: rtl/hcrc_engine_sva.sv
module hcrc_engine_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        resume_i,
    input logic [17:0] resume_state_i,
    input logic        valid_i,
    input logic        last_i,
    input logic        running,
    input logic        done_o,
    input logic [31:0] crc_o
);

    p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        crc_o[31:18] == 14'd0);

    // R2 and R4: a start pulse, alone or together with resume, yields all ones.
    p_start_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> crc_o == 32'h0003FFFF);

    p_start_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && resume_i) |=> crc_o[17:0] == 18'h3FFFF);

    p_resume_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_i && !start_i) |=> crc_o == {14'd0, $past(resume_state_i)});

    p_gap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !valid_i && !start_i && !resume_i) |=> $stable(crc_o));

    p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && valid_i && last_i && !start_i && !resume_i) |=> done_o);

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !start_i && !resume_i) |=> $stable(crc_o));

endmodule

bind hcrc_engine hcrc_engine_sva u_sva (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .resume_i       (resume_i),
    .resume_state_i (resume_state_i),
    .valid_i        (valid_i),
    .last_i         (last_i),
    .running        (running),
    .done_o         (done_o),
    .crc_o          (crc_o)
);

// File: tb/hcrc_engine_tb.sv
module hcrc_engine_tb;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        resume = 1'b0;
    logic [17:0] rstate = '0;

    logic        v8 = 0, l8 = 0, v16 = 0, l16 = 0, v32 = 0, l32 = 0;
    logic [7:0]  d8 = '0;
    logic [15:0] d16 = '0;
    logic [31:0] d32 = '0;
    logic        done8, done16, done32;
    logic [31:0] crc8, crc16, crc32;

    int checks = 0;
    int errors = 0;
    logic [7:0] msg [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    hcrc_engine #(.DATA_W(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .resume_i(resume),
        .resume_state_i(rstate), .valid_i(v32), .last_i(l32), .data_i(d32),
        .done_o(done32), .crc_o(crc32));

    hcrc_engine #(.DATA_W(16)) u_dut16 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .resume_i(resume),
        .resume_state_i(rstate), .valid_i(v16), .last_i(l16), .data_i(d16),
        .done_o(done16), .crc_o(crc16));

    hcrc_engine #(.DATA_W(8)) u_dut8 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .resume_i(resume),
        .resume_state_i(rstate), .valid_i(v8), .last_i(l8), .data_i(d8),
        .done_o(done8), .crc_o(crc8));

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_of(input int sel);
        return (sel == 0) ? crc8 : (sel == 1) ? crc16 : crc32;
    endfunction

    function automatic logic done_of(input int sel);
        return (sel == 0) ? done8 : (sel == 1) ? done16 : done32;
    endfunction

    // Bit-serial reference built from the polynomial definitions in R1.
    function automatic logic [31:0] model(input int off, input int n,
                                          input logic [17:0] init);
        logic [2:0] a;
        logic [6:0] b;
        logic [7:0] c;
        logic       bit_v;
        a = init[2:0];
        b = init[9:3];
        c = init[17:10];
        for (int k = off; k < off + n; k++) begin
            for (int i = 0; i < 8; i++) begin
                bit_v = msg[k][i];
                a = {a[1:0], 1'b0} ^ ((a[2] ^ bit_v) ? 3'b011 : 3'b000);
                b = {b[5:0], 1'b0} ^ ((b[6] ^ bit_v) ? 7'b1001111 : 7'b0);
                c = {c[6:0], 1'b0} ^ ((c[7] ^ bit_v) ? 8'h07 : 8'h00);
            end
        end
        return {14'd0, c, b, a};
    endfunction

    task automatic drive(input int sel, input logic v, input logic l,
                         input logic [31:0] w);
        case (sel)
            0: begin v8 = v; l8 = l; d8 = w[7:0]; end
            1: begin v16 = v; l16 = l; d16 = w[15:0]; end
            default: begin v32 = v; l32 = l; d32 = w; end
        endcase
    endtask

    task automatic pulse(input logic s, input logic r, input logic [17:0] val);
        @(negedge clk);
        start = s; resume = r; rstate = val;
        @(negedge clk);
        start = 0; resume = 0;
    endtask

    // Feeds n bytes from msg[off] into one instance; checks done timing (R6)
    // and, when gap is set, that an empty cycle holds the state (R5).
    task automatic feed(input int sel, input int off, input int n, input bit gap);
        int bw;
        int nw;
        logic [31:0] w;
        logic [31:0] held;
        bw = (sel == 0) ? 1 : (sel == 1) ? 2 : 4;
        nw = n / bw;
        for (int wi = 0; wi < nw; wi++) begin
            w = '0;
            for (int b = 0; b < bw; b++) w[b*8 +: 8] = msg[off + wi*bw + b];
            drive(sel, 1'b1, wi == nw - 1, w);
            @(negedge clk);
            if (wi == nw - 1) begin
                chk(done_of(sel) == 1'b1, "R6 done after last", {31'd0, done_of(sel)}, 32'd1);
                drive(sel, 1'b0, 1'b0, '0);
                @(negedge clk);
                chk(done_of(sel) == 1'b0, "R6 done single cycle", {31'd0, done_of(sel)}, 32'd0);
            end else begin
                if (wi == 0)
                    chk(done_of(sel) == 1'b0, "R6 no early done", {31'd0, done_of(sel)}, 32'd0);
                if (gap && wi == 0) begin
                    held = crc_of(sel);
                    drive(sel, 1'b0, 1'b0, 32'hA5A5A5A5);
                    @(negedge clk);
                    chk(crc_of(sel) == held, "R5 empty cycle holds", crc_of(sel), held);
                end
            end
        end
    endtask

    task automatic fill(input int pat);
        logic [7:0] s;
        s = 8'h5D;
        for (int k = 0; k < 64; k++) begin
            case (pat)
                0: msg[k] = 8'h00;
                1: msg[k] = 8'hFF;
                2: msg[k] = 8'(k);
                3: msg[k] = 8'(8'h80 >> (k % 8));
                default: begin
                    s = {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
                    msg[k] = s;
                end
            endcase
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int lens [5];
        logic [31:0] exp;
        logic [31:0] held;
        logic [17:0] cap;
        lens = '{4, 8, 20, 32, 64};

        repeat (3) @(negedge clk);
        chk(crc32 == 32'h0003FFFF, "R2 reset state", crc32, 32'h0003FFFF);
        chk(crc8 == 32'h0003FFFF, "R2 reset state w8", crc8, 32'h0003FFFF);
        chk(done32 == 1'b0, "R6 reset done low", {31'd0, done32}, 32'd0);
        rst_n = 1'b1;

        for (int c = 0; c < 5; c++) begin
            fill(c);
            pulse(1'b1, 1'b0, 18'h0);
            chk(crc32 == 32'h0003FFFF, "R2 start loads ones", crc32, 32'h0003FFFF);
            feed(0, 0, lens[c], c % 2 == 1);
            feed(1, 0, lens[c], c % 2 == 0);
            feed(2, 0, lens[c], 1'b1);
            exp = model(0, lens[c], 18'h3FFFF);
            chk(crc8 == exp, "R1 R5 R9 width 8", crc8, exp);
            chk(crc16 == exp, "R1 R5 R9 width 16", crc16, exp);
            chk(crc32 == exp, "R1 R5 R9 width 32", crc32, exp);
            held = crc32;
            @(negedge clk);
            v32 = 1; l32 = 1; d32 = 32'hDEADBEEF;
            @(negedge clk);
            @(negedge clk);
            v32 = 0; l32 = 0;
            chk(crc32 == held, "R7 words ignored outside run", crc32, held);
            chk(done32 == 1'b0, "R7 no done outside run", {31'd0, done32}, 32'd0);
        end

        pulse(1'b1, 1'b1, 18'h2A5A5);
        chk(crc32 == 32'h0003FFFF, "R4 start beats resume", crc32, 32'h0003FFFF);

        fill(4);
        pulse(1'b0, 1'b1, 18'h15C3A);
        chk(crc32 == 32'h00015C3A, "R3 resume loads state", crc32, 32'h00015C3A);
        feed(2, 0, 16, 1'b0);
        exp = model(0, 16, 18'h15C3A);
        chk(crc32 == exp, "R3 run from resumed state", crc32, exp);

        fill(2);
        for (int k = 0; k < 8; k++) msg[k] = 8'(8'hC0 + k);
        pulse(1'b1, 1'b0, 18'h0);
        feed(2, 0, 8, 1'b0);
        feed(0, 0, 8, 1'b0);
        cap = crc32[17:0];
        exp = model(0, 8, 18'h3FFFF);
        chk(crc32 == exp, "R8 static part", crc32, exp);
        chk(crc8 == exp, "R8 static part w8", crc8, exp);
        pulse(1'b1, 1'b0, 18'h0);
        pulse(1'b0, 1'b1, cap);
        feed(2, 8, 24, 1'b1);
        feed(0, 8, 24, 1'b0);
        exp = model(0, 32, 18'h3FFFF);
        chk(crc32 == exp, "R8 resumed equals full", crc32, exp);
        chk(crc8 == exp, "R8 resumed equals full w8", crc8, exp);
        chk(crc32[31:18] == 14'd0, "R1 upper bits zero", crc32, exp);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule